// File: doc/BRIEF.md
# Serial Read CRC-16 Appender

This block sits at the tail of a serial read path, clocked by the serial clock. Each data bit that the read logic shifts out goes through it to the output pin stage. A 16-bit CRC runs over every bit that passes. The upstream logic marks the final bit of a continuous read sequence. If the checksum feature is enabled at that moment, the block sends the 16 checksum bits straight after that final bit, then lets the next read sequence of the same transaction continue.

While the checksum is being sent, the block raises `hold` so that the upstream read logic pauses. Cycles in which upstream presents no data bit do not affect the checksum. Command and address cycles are handled this way, because upstream simply does not mark them valid. Raising chip select (active low) clears the running checksum and cuts off any checksum still being sent.

Top module: `crc_append_sdo`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_crc` and `hold` are 0.
- R2: A bit is accepted when `in_valid` is 1, `hold` is 0 and `cs_n` is 0. It appears on `out_bit` one clock later, with `out_valid`=1 and `out_crc`=0.
- R3: The checksum uses polynomial 0x8005 (x^16+x^15+x^2+1) with a start value of 0x0000 and no final inversion. Bits enter in the order they were accepted. The nine ASCII bytes "123456789", each sent MSB first, give 0xFEE8.
- R4: If `crc_en` is 1 when the bit with `in_last`=1 is accepted, the 16 checksum bits follow that bit on the next 16 consecutive clocks. They go out MSB first, each with `out_valid`=1 and `out_crc`=1.
- R5: `hold` is 1 for exactly the 16 clocks of checksum insertion. Inputs presented while `hold` is 1 are ignored and produce no output bit.
- R6: If `crc_en` is 0 when the last bit is accepted, no checksum bits follow and `out_crc` stays 0.
- R7: The checksum restarts from 0x0000 for each read sequence, whatever the value of `crc_en` at the end of the previous sequence.
- R8: `cs_n` high clears the running checksum and stops any insertion in progress. On the next clock `out_valid` and `hold` are 0.
- R9: A cycle with `in_valid`=0 produces no output bit and does not change the checksum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| crc_en | input | 1 | Checksum insertion enable |
| in_valid | input | 1 | A read data bit is presented |
| in_bit | input | 1 | Read data bit |
| in_last | input | 1 | Presented bit ends the read sequence |
| hold | output | 1 | Upstream must pause (checksum in progress) |
| out_valid | output | 1 | `out_bit` carries a bit this cycle |
| out_bit | output | 1 | Serial output bit |
| out_crc | output | 1 | `out_bit` is a checksum bit |

## Verification
The in-RTL assertions cover the cycle-level contract on every clock. They check one-clock pass-through of accepted bits, silence on idle cycles, that chip select clears the outputs, and that checksum bits only follow an enabled final bit. The checksum value itself, its MSB-first order, the exact 16-clock length of `hold`, and the restart of the checksum after disabled sequences, gaps and chip-select aborts can only be shown by the bench. It does this by comparing whole captured output streams with a reference model.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'h0000;
endpackage

// File: rtl/crc_bit_engine.sv
module crc_bit_engine #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8005,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         advance,
  input  logic         din,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_next
);
  logic fb;
  assign fb = crc_q[W-1] ^ din;

  // one LFSR step per generated bit position
  for (genvar i = 0; i < W; i++) begin : g_step
    if (i == 0) begin : g_lsb
      assign crc_next[i] = POLY[i] & fb;
    end else begin : g_upper
      assign crc_next[i] = crc_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (advance) crc_q <= crc_next;
  end
endmodule

// File: rtl/crc_tail_shifter.sv
module crc_tail_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         msb
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= load_val;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      sh  <= {sh[W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
      if (cnt == CNT_LAST) busy <= 1'b0;
    end
  end

  assign msb = sh[W-1];

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);  // R5
endmodule

// File: rtl/crc_append_sdo.sv
module crc_append_sdo
  import crc_app_pkg::*;
#(
  parameter int              W    = CRC_W,
  parameter logic [W-1:0]    POLY = CRC_POLY,
  parameter logic [W-1:0]    INIT = CRC_INIT
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic crc_en,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic hold,
  output logic out_valid,
  output logic out_bit,
  output logic out_crc
);
  logic         accept;
  logic         seq_done;
  logic         tail_busy;
  logic         tail_msb;
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_next;

  assign accept   = in_valid && !hold && !cs_n;
  assign seq_done = accept && in_last;
  assign hold     = tail_busy;

  crc_bit_engine #(.W(W), .POLY(POLY), .INIT(INIT)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .clear    (cs_n || seq_done),
    .advance  (accept),
    .din      (in_bit),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  crc_tail_shifter #(.W(W)) u_tail (
    .clk      (clk),
    .rst      (rst),
    .abort    (cs_n),
    .load     (seq_done && crc_en),
    .load_val (crc_next),
    .busy     (tail_busy),
    .msb      (tail_msb)
  );

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_crc   <= 1'b0;
    end else if (tail_busy) begin
      out_valid <= 1'b1;
      out_bit   <= tail_msb;
      out_crc   <= 1'b1;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_bit   <= in_bit;
      out_crc   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_crc   <= 1'b0;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hold && !cs_n) |=> (out_valid && !out_crc && out_bit == $past(in_bit)));  // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !hold) |=> !out_valid);  // R9
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!out_valid && !hold));  // R8
  AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(in_valid && in_last && crc_en && !cs_n));  // R4
  AST_NO_TAIL_OFF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !crc_en && !hold && !cs_n) |=> !hold);  // R6
  AST_CRC_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_crc |-> (out_valid && $past(hold)));  // R5
endmodule

// File: tb/crc_append_sdo_test.sv
module crc_append_sdo_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic crc_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_last = 1'b0;
  logic hold, out_valid, out_bit, out_crc;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  crc_append_sdo uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .crc_en(crc_en),
    .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
    .hold(hold), .out_valid(out_valid), .out_bit(out_bit), .out_crc(out_crc)
  );

  logic cap_bit [0:127];
  logic cap_crc [0:127];
  int   cap_n  = 0;
  int   hold_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 128) begin
      cap_bit[cap_n] = out_bit;
      cap_crc[cap_n] = out_crc;
      cap_n = cap_n + 1;
    end
    if (hold) hold_n = hold_n + 1;
  end

  localparam int NV = 6;
  localparam logic [71:0] V_DATA [0:NV-1] = '{
    72'h313233343536373839, 72'hA5C3, 72'h01, 72'hDEADBEEF, 72'h1, 72'hFFFFFF};
  localparam int   V_LEN  [0:NV-1] = '{72, 16, 8, 32, 1, 24};
  localparam logic V_EN   [0:NV-1] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic V_GAP  [0:NV-1] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic V_PUSH [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [71:0] d, input int len);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      logic fb;
      fb = c[15] ^ d[len-1-i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  task automatic drive_bit(input logic b, input logic last, input logic gap);
    while (hold) @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic send_seq(input logic [71:0] d, input int len, input logic en,
                          input logic gap, input logic push);
    cap_n = 0; hold_n = 0;
    crc_en = en;
    for (int i = 0; i < len; i++) drive_bit(d[len-1-i], i == len-1, gap);
    if (push) begin
      in_valid = 1'b1; in_bit = 1'b1;
      @(negedge clk);
      while (hold) @(negedge clk);
      in_valid = 1'b0;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic check_stream(input logic [71:0] d, input int len, input logic en);
    logic [15:0] exp_crc, got;
    int nexp, bad_d, bad_f;
    exp_crc = ref_crc(d, len);
    nexp = len + (en ? 16 : 0);
    chk(cap_n == nexp, en ? "R4 bit count" : "R6 bit count", cap_n, nexp);
    if (cap_n == nexp) begin
      bad_d = 0; bad_f = 0; got = '0;
      for (int i = 0; i < len; i++) begin
        if (cap_bit[i] !== d[len-1-i]) bad_d++;
        if (cap_crc[i] !== 1'b0) bad_f++;
      end
      chk(bad_d == 0 && bad_f == 0, "R2 data bits", bad_d + bad_f, 0);
      if (en) begin
        bad_f = 0;
        for (int k = 0; k < 16; k++) begin
          got[15-k] = cap_bit[len+k];
          if (cap_crc[len+k] !== 1'b1) bad_f++;
        end
        chk(got == exp_crc, "R3 checksum value", got, exp_crc);
        chk(bad_f == 0, "R4 checksum flag", bad_f, 0);
      end
    end
    chk(hold_n == (en ? 16 : 0), "R5 hold length", hold_n, en ? 16 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_crc && !hold, "R1 reset outputs", {out_valid, out_crc, hold}, 0);
    rst = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_crc && !hold, "R1 after reset", {out_valid, out_crc, hold}, 0);

    // table walk: R7 restart is covered by entry 2 following disabled entry 1
    for (int v = 0; v < NV; v++) begin
      send_seq(V_DATA[v], V_LEN[v], V_EN[v], V_GAP[v], V_PUSH[v]);
      check_stream(V_DATA[v], V_LEN[v], V_EN[v]);
    end

    // R3 known check value
    send_seq(72'h313233343536373839, 72, 1'b1, 1'b0, 1'b0);
    begin
      logic [15:0] got = '0;
      for (int k = 0; k < 16; k++) got[15-k] = cap_bit[72+k];
      chk(got == 16'hFEE8, "R3 check value", got, 16'hFEE8);
    end

    // R9 long idle gap between sequences: nothing comes out
    cap_n = 0;
    repeat (10) @(negedge clk);
    chk(cap_n == 0, "R9 idle output", cap_n, 0);

    // R8 abort mid sequence: partial bits must not leak into the next checksum
    crc_en = 1'b1;
    for (int i = 0; i < 5; i++) drive_bit(1'b1, 1'b0, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !hold, "R8 cs output idle", {out_valid, hold}, 0);
    cs_n = 1'b0;
    send_seq(72'h3C, 8, 1'b1, 1'b0, 1'b0);
    check_stream(72'h3C, 8, 1'b1);

    // R8 abort during insertion
    cap_n = 0;
    for (int i = 0; i < 8; i++) drive_bit(i[0], i == 7, 1'b0);
    repeat (4) @(negedge clk);
    chk(hold == 1'b1, "R5 hold during insertion", hold, 1);
    cs_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !hold, "R8 insertion aborted", {out_valid, hold}, 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !hold, "R8 stays idle", {out_valid, hold}, 0);
    send_seq(72'hC3, 8, 1'b1, 1'b0, 1'b0);
    check_stream(72'hC3, 8, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule